// File: doc/BRIEF.md
# Time-Code Distribution and Validation Unit

This block keeps the master time counter of a multi-port packet router. Every port, whether a network link or a host-side interface, can hand the unit an 8-bit time-code: a 6-bit count in bits [5:0] and two control flags in bits [7:6]. The unit takes at most one such code per cycle. It stores every accepted code in the master register. When the code's count is exactly one more than the stored count, modulo 64, the unit raises a tick and forwards the code to every other enabled port.

Two switches decide whether a code is accepted. A flag-filter input rejects codes whose flags are not 00. A global disable input blocks all acceptance and forwarding. Each port also has its own enable bit, which gates both its incoming and its outgoing codes. All outputs are registered: a code presented in cycle t shows up on the register output, the tick and the forwarding strobes after the next rising clock edge.

Top module: `tc_dist_unit`

## Requirements
- R1: While rst is high at a clock edge, time_reg becomes 0x00 (count 0, flags 00), and tick and every tx_vld bit become 0.
- R2: An accepted code is stored whole in time_reg (count in bits [5:0], flags in bits [7:6]) one cycle later, even when its count is not the successor.
- R3: tick is high for exactly the one cycle after an accepted code whose count equals the stored count plus one modulo 64, including the wrap from 63 to 0.
- R4: An accepted code whose count is not the successor, and any cycle with no code, produces no tick and no tx_vld.
- R5: On a tick, tx_vld[j] is high for one cycle for every enabled port j other than the source port, and tx_code slice j (bits 8j+7..8j) holds the forwarded code.
- R6: When flt_en is 1, a code with flags other than 00 is dropped: time_reg does not change and no tick or forwarding occurs.
- R7: When flt_en is 0, the flag value does not affect acceptance, and any flag value is stored and forwarded.
- R8: A port whose port_en bit is 0 has its rx code ignored and receives no tx_vld.
- R9: While glb_dis is 1, no code is accepted: time_reg holds, and tick and tx_vld stay 0.
- R10: When several enabled ports present a code in the same cycle, only the lowest-numbered one is used and the others are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| glb_dis | input | 1 | Global time-code disable |
| flt_en | input | 1 | Require control flags 00 to accept |
| port_en | input | N_PORTS | Per-port receive/transmit enable |
| rx_vld | input | N_PORTS | Per-port time-code valid |
| rx_code | input | 8*N_PORTS | Per-port time-code, port i in bits 8i+7..8i |
| tx_vld | output | N_PORTS | Per-port one-cycle forward strobe |
| tx_code | output | 8*N_PORTS | Per-port forwarded code |
| tick | output | 1 | One-cycle tick on a successor code |
| time_reg | output | 8 | Stored master count and flags |

## Verification
The checker watches every cycle for the following properties. A tick always comes with a count advance of exactly one. Forward strobes appear only together with a tick, and only toward ports that were enabled. Each forwarded code matches the new master value. A cycle under global disable leaves the master value unchanged and produces no tick or strobe. Under filtering, any change to the master value carries flags 00. Lowest-port arbitration, exclusion of the source port, and the drop of a non-successor code show only in the bench scenarios, because they depend on which inputs were presented and which port sent them.

// File: rtl/tc_pkg.sv
package tc_pkg;
  parameter int CNT_W = 6;
  parameter int FLG_W = 2;
  localparam int TC_W = CNT_W + FLG_W;

  typedef struct packed {
    logic [FLG_W-1:0] flags;
    logic [CNT_W-1:0] count;
  } tcode_t;
endpackage

// File: rtl/tc_arbiter.sv
module tc_arbiter
  import tc_pkg::*;
#(
  parameter int N_PORTS = 4,
  localparam int IDX_W = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
  input  logic [N_PORTS-1:0] req,
  input  tcode_t             codes [N_PORTS],
  output logic               gnt_vld,
  output logic [IDX_W-1:0]   gnt_idx,
  output tcode_t             gnt_code
);
  // Scan from the top down so the lowest requesting port is the one kept.
  always_comb begin
    gnt_vld  = 1'b0;
    gnt_idx  = '0;
    gnt_code = '0;
    for (int i = N_PORTS - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt_vld  = 1'b1;
        gnt_idx  = IDX_W'(i);
        gnt_code = codes[i];
      end
    end
  end
endmodule

// File: rtl/tc_validator.sv
module tc_validator
  import tc_pkg::*;
(
  input  logic             in_vld,
  input  tcode_t           in_code,
  input  logic [CNT_W-1:0] cur_count,
  input  logic             flt_en,
  output logic             store,
  output logic             advance
);
  logic flags_ok;
  logic [CNT_W-1:0] next_count;

  always_comb begin
    flags_ok   = !flt_en || (in_code.flags == '0);
    next_count = cur_count + 1'b1;
    store      = in_vld && flags_ok;
    advance    = store && (in_code.count == next_count);
  end
endmodule

// File: rtl/tc_fanout.sv
module tc_fanout
  import tc_pkg::*;
#(
  parameter int N_PORTS = 4,
  localparam int IDX_W = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    fwd,
  input  logic [IDX_W-1:0]        src_idx,
  input  tcode_t                  code,
  input  logic [N_PORTS-1:0]      port_en,
  output logic [N_PORTS-1:0]      tx_vld,
  output logic [N_PORTS*TC_W-1:0] tx_code
);
  for (genvar j = 0; j < N_PORTS; j++) begin : g_port
    logic dest;
    assign dest = fwd && port_en[j] && (src_idx != IDX_W'(j));

    always_ff @(posedge clk) begin
      if (rst) begin
        tx_vld[j]                 <= 1'b0;
        tx_code[j*TC_W +: TC_W]   <= '0;
      end else begin
        tx_vld[j] <= dest;
        if (dest) tx_code[j*TC_W +: TC_W] <= code;
      end
    end
  end
endmodule

// File: rtl/tc_dist_unit.sv
module tc_dist_unit
  import tc_pkg::*;
#(
  parameter int N_PORTS = 4,
  localparam int IDX_W = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    glb_dis,
  input  logic                    flt_en,
  input  logic [N_PORTS-1:0]      port_en,
  input  logic [N_PORTS-1:0]      rx_vld,
  input  logic [N_PORTS*TC_W-1:0] rx_code,
  output logic [N_PORTS-1:0]      tx_vld,
  output logic [N_PORTS*TC_W-1:0] tx_code,
  output logic                    tick,
  output logic [TC_W-1:0]         time_reg
);
  tcode_t             codes [N_PORTS];
  logic [N_PORTS-1:0] req;
  logic               gnt_vld;
  logic [IDX_W-1:0]   gnt_idx;
  tcode_t             gnt_code;
  tcode_t             master;
  logic               store;
  logic               advance;

  for (genvar i = 0; i < N_PORTS; i++) begin : g_unpack
    assign codes[i] = rx_code[i*TC_W +: TC_W];
  end

  assign req = rx_vld & port_en & {N_PORTS{~glb_dis}};

  tc_arbiter #(.N_PORTS(N_PORTS)) arb_i (
    .req      (req),
    .codes    (codes),
    .gnt_vld  (gnt_vld),
    .gnt_idx  (gnt_idx),
    .gnt_code (gnt_code)
  );

  tc_validator val_i (
    .in_vld    (gnt_vld),
    .in_code   (gnt_code),
    .cur_count (master.count),
    .flt_en    (flt_en),
    .store     (store),
    .advance   (advance)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      master <= '0;
      tick   <= 1'b0;
    end else begin
      if (store) master <= gnt_code;
      tick <= advance;
    end
  end

  assign time_reg = master;

  tc_fanout #(.N_PORTS(N_PORTS)) fan_i (
    .clk     (clk),
    .rst     (rst),
    .fwd     (advance),
    .src_idx (gnt_idx),
    .code    (gnt_code),
    .port_en (port_en),
    .tx_vld  (tx_vld),
    .tx_code (tx_code)
  );
endmodule

// File: rtl/tc_dist_chk.sv
module tc_dist_chk
  import tc_pkg::*;
#(
  parameter int N_PORTS = 4
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    glb_dis,
  input logic                    flt_en,
  input logic [N_PORTS-1:0]      port_en,
  input logic [N_PORTS-1:0]      rx_vld,
  input logic [N_PORTS-1:0]      tx_vld,
  input logic [N_PORTS*TC_W-1:0] tx_code,
  input logic                    tick,
  input logic [TC_W-1:0]         time_reg
);
  logic pv;
  always_ff @(posedge clk) pv <= !rst;

  AST_TICK_INC: assert property (@(posedge clk) disable iff (rst)
    (pv && tick) |-> (time_reg[CNT_W-1:0] == CNT_W'($past(time_reg[CNT_W-1:0]) + 1'b1))); // R3

  AST_TICK_HAS_SRC: assert property (@(posedge clk) disable iff (rst)
    (pv && tick) |-> $past(|(rx_vld & port_en))); // R4

  AST_FWD_WITH_TICK: assert property (@(posedge clk) disable iff (rst)
    (|tx_vld) |-> tick); // R5

  AST_GDIS_QUIET: assert property (@(posedge clk) disable iff (rst)
    (pv && $past(glb_dis)) |-> (!tick && tx_vld == '0 && $stable(time_reg))); // R9

  AST_FILTER_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (pv && $past(flt_en) && !$stable(time_reg)) |-> (time_reg[TC_W-1:CNT_W] == '0)); // R6

  for (genvar j = 0; j < N_PORTS; j++) begin : g_chk
    AST_TX_ENABLED: assert property (@(posedge clk) disable iff (rst)
      (pv && tx_vld[j]) |-> $past(port_en[j])); // R8

    AST_TX_CODE_MATCH: assert property (@(posedge clk) disable iff (rst)
      tx_vld[j] |-> (tx_code[j*TC_W +: TC_W] == time_reg)); // R5
  end
endmodule

bind tc_dist_unit tc_dist_chk #(.N_PORTS(N_PORTS)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .glb_dis  (glb_dis),
  .flt_en   (flt_en),
  .port_en  (port_en),
  .rx_vld   (rx_vld),
  .tx_vld   (tx_vld),
  .tx_code  (tx_code),
  .tick     (tick),
  .time_reg (time_reg)
);

// File: tb/tc_dist_unit_tb.sv
`timescale 1ns/1ps
module tc_dist_unit_tb_top;
  localparam int NP = 4;

  logic          clk = 1'b0;
  logic          rst;
  logic          glb_dis;
  logic          flt_en;
  logic [NP-1:0] port_en;
  logic [NP-1:0] rx_vld;
  logic [NP*8-1:0] rx_code;
  logic [NP-1:0] tx_vld;
  logic [NP*8-1:0] tx_code;
  logic          tick;
  logic [7:0]    time_reg;

  int n_vec = 0;
  int n_bad = 0;
  logic [7:0] m;   // bench model of the master value

  always #2.5 clk = ~clk;

  tc_dist_unit #(.N_PORTS(NP)) dut_i (
    .clk(clk), .rst(rst), .glb_dis(glb_dis), .flt_en(flt_en),
    .port_en(port_en), .rx_vld(rx_vld), .rx_code(rx_code),
    .tx_vld(tx_vld), .tx_code(tx_code), .tick(tick), .time_reg(time_reg)
  );

  // Apply one cycle of stimulus, predict from the requirements, compare.
  task automatic step(input logic [NP-1:0] vld, input logic [NP-1:0] en,
                      input logic gd, input logic fl,
                      input logic [NP*8-1:0] codes, input string tag);
    int         sel;
    logic       e_tick;
    logic [NP-1:0] e_vld;
    logic [7:0] c;
    logic       bad;
    @(negedge clk);
    rx_vld = vld; port_en = en; glb_dis = gd; flt_en = fl; rx_code = codes;
    sel = -1;
    for (int i = NP - 1; i >= 0; i--) if (vld[i] && en[i]) sel = i;   // R10
    if (gd) sel = -1;                                                   // R9
    e_tick = 1'b0;
    e_vld  = '0;
    c      = '0;
    if (sel >= 0) begin
      c = codes[sel*8 +: 8];
      if (!(fl && c[7:6] != 2'b00)) begin                               // R6, R7
        if (c[5:0] == 6'(m[5:0] + 6'd1)) begin                          // R3
          e_tick = 1'b1;
          for (int j = 0; j < NP; j++) e_vld[j] = en[j] && (j != sel);  // R5, R8
        end
        m = c;                                                          // R2
      end
    end
    @(posedge clk);
    #1;
    n_vec++;
    bad = (tick !== e_tick) || (tx_vld !== e_vld) || (time_reg !== m);
    for (int j = 0; j < NP; j++)
      if (e_vld[j] && tx_code[j*8 +: 8] !== c) bad = 1'b1;
    if (bad) begin
      n_bad++;
      $display("FAIL %s: tick=%b tx_vld=%b time_reg=%h tx_code=%h expected tick=%b tx_vld=%b time_reg=%h code=%h",
               tag, tick, tx_vld, time_reg, tx_code, e_tick, e_vld, m, c);
    end
  endtask

  function automatic logic [NP*8-1:0] all_ports(input logic [7:0] c);
    logic [NP*8-1:0] r;
    for (int i = 0; i < NP; i++) r[i*8 +: 8] = c;
    return r;
  endfunction

  initial begin
    rst = 1'b1; glb_dis = 1'b0; flt_en = 1'b0; port_en = '1; rx_vld = '0; rx_code = '0;
    m = 8'h00;
    repeat (3) @(posedge clk);
    #1;
    n_vec++;
    if (time_reg !== 8'h00 || tick !== 1'b0 || tx_vld !== '0) begin
      n_bad++;
      $display("FAIL R1: time_reg=%h tick=%b tx_vld=%b expected 00 0 0", time_reg, tick, tx_vld);
    end
    @(negedge clk);
    rst = 1'b0;

    // R3/R5/R7: successor sweep through the wrap, rotating source and flags
    for (int k = 0; k < 130; k++) begin
      logic [7:0] c;
      c = {2'(k / 4), 6'(m[5:0] + 6'd1)};
      step(NP'(1) << (k % NP), '1, 1'b0, 1'b0, all_ports(c), "R3/R5/R7");
    end

    // R2/R4: every non-successor offset, then an idle cycle
    for (int d = 0; d < 64; d++) begin
      if (d != 1) begin
        logic [7:0] c;
        c = {2'(d % 4), 6'(m[5:0] + 6'(d))};
        step(NP'(1) << (d % NP), '1, 1'b0, 1'b0, all_ports(c), "R2/R4");
        step('0, '1, 1'b0, 1'b0, '0, "R4");
      end
    end

    // R6: filtering on, every flag value with a successor count
    for (int f = 0; f < 4; f++)
      for (int s = 0; s < NP; s++) begin
        logic [7:0] c;
        c = {2'(f), 6'(m[5:0] + 6'd1)};
        step(NP'(1) << s, '1, 1'b0, 1'b1, all_ports(c), "R6");
      end

    // R8: every enable mask against every source
    for (int en = 0; en < (1 << NP); en++)
      for (int s = 0; s < NP; s++) begin
        logic [7:0] c;
        c = {2'b00, 6'(m[5:0] + 6'd1)};
        step(NP'(1) << s, NP'(en), 1'b0, 1'b0, all_ports(c), "R8");
      end

    // R9: global disable with every request mask
    for (int v = 0; v < (1 << NP); v++) begin
      logic [7:0] c;
      c = {2'b00, 6'(m[5:0] + 6'd1)};
      step(NP'(v), '1, 1'b1, 1'b0, all_ports(c), "R9");
    end

    // R10: simultaneous requests, winner identified by its flags
    for (int v = 1; v < (1 << NP); v++) begin
      logic [NP*8-1:0] cs;
      for (int i = 0; i < NP; i++) cs[i*8 +: 8] = {2'(i), 6'(m[5:0] + 6'd1)};
      step(NP'(v), '1, 1'b0, 1'b0, cs, "R10");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule